// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Alarm Controller

This block drives the active-low interrupt request of a real-time clock. It keeps three event flags: periodic, alarm and update-ended. A flag is set by its own event whether or not its enable is on. Each enable only decides whether its flag can pull the interrupt line low. The alarm event is found by comparing the current hours, minutes and seconds bytes with three alarm bytes. An alarm byte whose two top bits are both 1 is a wildcard and matches any value.

The host writes a small control word. It holds a set-mode bit, the three interrupt enables and a square-wave enable. The square-wave enable passes an externally generated rate clock to the square-wave pin, or holds the pin low. A flag read strobe returns the three flags plus a summary bit and clears the flags. The periodic rate source and the timekeeping counters sit outside this block.

The block has two synchronous active-low reset inputs. The host reset clears only some control bits. The power-on initialisation input brings every control bit to a known value.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: The periodic flag (flag_q bit 2) is set one cycle after `per_tick` is high, whatever the periodic enable (ctl bit 3) holds. The enable only decides whether that flag drives `irq_n` low.
- R2: In a cycle with `upd_done` high, the alarm flag (flag_q bit 1) is set on the next cycle when every one of the three time bytes matches its alarm byte. An alarm byte matches when it equals its time byte, or when its bits [7:6] are 2'b11.
- R3: The update-ended flag (flag_q bit 0) is set one cycle after `upd_done` is high, whatever the update enable (ctl bit 1) holds.
- R4: `irq_n` is 0 exactly when at least one flag is set together with its enable. The pairs are: periodic with bit 3, alarm with bit 2, update-ended with bit 1. Otherwise `irq_n` is 1.
- R5: `flag_q` shows {summary, periodic, alarm, update-ended} in bits [3:0]. The summary bit equals the inverse of `irq_n`. A cycle with `flag_rd` high clears all three flags on the next cycle.
- R6: When a flag's set event arrives in the same cycle as `flag_rd`, that flag is set on the next cycle.
- R7: A cycle with `rst_n` low (and `pwr_on_n` high) clears the periodic enable, the update enable, the square-wave enable and all flags. The set-mode bit (ctl bit 4) and the alarm enable (ctl bit 2) keep their values.
- R8: A cycle with `pwr_on_n` low sets `ctl_q` to 5'b00001 and clears all flags. This input takes priority over `rst_n` and over writes.
- R9: A write that takes the set-mode bit from 0 to 1 leaves the update enable at 0, even if the same write sets it. A write of the update enable while set-mode is already 1 stores the written value.
- R10: `sqw_o` follows `sqw_src` while the square-wave enable (ctl bit 0) is 1, and is 0 while it is 0.
- R11: A cycle with `ctl_wr` high loads `ctl_wdata` into `ctl_q` on the next cycle. The bit layout is [4] set-mode, [3] periodic enable, [2] alarm enable, [1] update enable, [0] square-wave enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Host reset, synchronous, active low |
| pwr_on_n | input | 1 | Power-on initialisation, synchronous, active low |
| per_tick | input | 1 | One-cycle pulse at the selected periodic rate |
| upd_done | input | 1 | One-cycle pulse when a time update completes |
| tim_hr | input | 8 | Current hours byte |
| tim_min | input | 8 | Current minutes byte |
| tim_sec | input | 8 | Current seconds byte |
| alm_hr | input | 8 | Hours alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_sec | input | 8 | Seconds alarm byte |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write data |
| ctl_q | output | 5 | Current control word |
| flag_rd | input | 1 | Flag read strobe; clears flags |
| flag_q | output | 4 | Summary bit and three flags |
| sqw_src | input | 1 | Rate-selected square wave source |
| sqw_o | output | 1 | Gated square wave |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that `per_tick` and `upd_done` are synchronous to `clk`. They also assume that the time and alarm bytes are stable in any cycle where `upd_done` is high. The update-enable property further assumes that set-mode changes only through `ctl_wr`.

The random stimulus drives every input on the falling edge. It draws the time and alarm bytes from a small value set, so exact matches are frequent, and makes about a quarter of the alarm bytes wildcards. It also places rare host-reset and power-on cycles among random writes, reads and events, so that coincident set and clear cases occur often.

// File: rtl/rtc_irq_pkg.sv
// Shared types and constants for the RTC interrupt controller.
// Assumes: a five-bit control word and three event flags.
package rtc_irq_pkg;

    // Host control word, MSB first as it appears on the ports.
    typedef struct packed {
        logic set_mode;
        logic pie;
        logic aie;
        logic uie;
        logic sqwe;
    } ctl_t;

    localparam int CTL_W   = $bits(ctl_t);
    localparam int N_FLAG  = 3;
    localparam int FLG_UF  = 0;
    localparam int FLG_AF  = 1;
    localparam int FLG_PF  = 2;
    localparam logic [1:0] WILD_TAG = 2'b11;

    localparam ctl_t CTL_PWR_INIT = '{set_mode: 1'b0, pie: 1'b0, aie: 1'b0,
                                      uie: 1'b0, sqwe: 1'b1};

endpackage

// File: rtl/rtc_alarm_cmp.sv
// Alarm comparator: matches N_FIELDS time bytes against alarm bytes.
// A byte whose two top bits equal WILD_TAG matches any time value.
// Assumes: inputs are stable while the result is sampled.
module rtc_alarm_cmp
    import rtc_irq_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int N_FIELDS = 3
) (
    input  logic [N_FIELDS-1:0][BYTE_W-1:0] tim,
    input  logic [N_FIELDS-1:0][BYTE_W-1:0] alm,
    output logic                            all_hit
);
    localparam int TAG_LO = BYTE_W - 2;

    logic [N_FIELDS-1:0] hit;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        // Per-field match: wildcard tag or exact equality.
        always_comb begin
            hit[i] = (alm[i][BYTE_W-1:TAG_LO] == WILD_TAG) || (alm[i] == tim[i]);
        end
    end

    // All fields must match for an alarm.
    always_comb begin
        all_hit = &hit;
    end

endmodule

// File: rtl/rtc_flag_bank.sv
// Event flag bank: each flag is sticky until a read strobe clears it.
// A set event in the same cycle as the read strobe wins.
// Assumes: clr_n is a synchronous active-low clear.
module rtc_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [N-1:0] set,
    input  logic         rd,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Sticky flag with set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!clr_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (rd)     q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!clr_n)
            set[i] |=> q[i]);  // R6
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!clr_n)
            (rd && !set[i]) |=> !q[i]);  // R5
    end

endmodule

// File: rtl/rtc_ctl_reg.sv
// Host control register: set-mode, three interrupt enables, square-wave enable.
// Power-on initialises all bits; host reset clears only pie, uie and sqwe.
// Set-mode rising through a write forces the update enable to 0.
// Assumes: set_mode changes only through wr.
module rtc_ctl_reg
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on_n,
    input  logic wr,
    input  ctl_t wdata,
    output ctl_t q
);

    // Control word update with power-on > reset > write priority.
    always_ff @(posedge clk) begin
        if (!pwr_on_n) begin
            q <= CTL_PWR_INIT;
        end else if (!rst_n) begin
            q.pie  <= 1'b0;
            q.uie  <= 1'b0;
            q.sqwe <= 1'b0;
        end else if (wr) begin
            q <= wdata;
            if (!q.set_mode && wdata.set_mode) q.uie <= 1'b0;
        end
    end

    AST_UIE_ON_SET: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        $rose(q.set_mode) |-> !q.uie);  // R9
    AST_RST_CLEARS: assert property (@(posedge clk)
        (pwr_on_n && !rst_n) |=> (!q.pie && !q.uie && !q.sqwe));  // R7
    AST_PWR_INIT: assert property (@(posedge clk)
        !pwr_on_n |=> (q.sqwe && !q.pie && !q.aie && !q.uie && !q.set_mode));  // R8

endmodule

// File: rtl/rtc_irq_ctrl.sv
// RTC interrupt and alarm controller (top).
// Sets periodic, alarm and update-ended flags from their events, gates them
// onto an active-low interrupt line through host enables, and gates the
// square-wave output. Assumes all inputs are synchronous to clk.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on_n,
    input  logic              per_tick,
    input  logic              upd_done,
    input  logic [BYTE_W-1:0] tim_hr,
    input  logic [BYTE_W-1:0] tim_min,
    input  logic [BYTE_W-1:0] tim_sec,
    input  logic [BYTE_W-1:0] alm_hr,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    input  logic              flag_rd,
    output logic [N_FLAG:0]   flag_q,
    input  logic              sqw_src,
    output logic              sqw_o,
    output logic              irq_n
);
    localparam int N_FIELDS = 3;
    localparam logic [1:0] WILD = WILD_TAG;

    ctl_t                            ctl;
    logic                            alarm_hit;
    logic                            flag_clr_n;
    logic [N_FLAG-1:0]               flag_set;
    logic [N_FLAG-1:0]               flags;
    logic [N_FLAG-1:0]               en_vec;
    logic                            irq_cond;
    logic [N_FIELDS-1:0][BYTE_W-1:0] tim_vec;
    logic [N_FIELDS-1:0][BYTE_W-1:0] alm_vec;

    // Pack the time and alarm bytes, hours in the top field.
    always_comb begin
        tim_vec = {tim_hr, tim_min, tim_sec};
        alm_vec = {alm_hr, alm_min, alm_sec};
    end

    rtc_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_on_n (pwr_on_n),
        .wr       (ctl_wr),
        .wdata    (ctl_t'(ctl_wdata)),
        .q        (ctl)
    );

    rtc_alarm_cmp #(.BYTE_W(BYTE_W), .N_FIELDS(N_FIELDS)) u_cmp (
        .tim     (tim_vec),
        .alm     (alm_vec),
        .all_hit (alarm_hit)
    );

    // Flag set events and the combined clear.
    always_comb begin
        flag_set         = '0;
        flag_set[FLG_PF] = per_tick;
        flag_set[FLG_AF] = upd_done && alarm_hit;
        flag_set[FLG_UF] = upd_done;
        flag_clr_n       = rst_n && pwr_on_n;
    end

    rtc_flag_bank #(.N(N_FLAG)) u_flags (
        .clk   (clk),
        .clr_n (flag_clr_n),
        .set   (flag_set),
        .rd    (flag_rd),
        .q     (flags)
    );

    // Interrupt condition: any flag together with its enable.
    always_comb begin
        en_vec         = '0;
        en_vec[FLG_PF] = ctl.pie;
        en_vec[FLG_AF] = ctl.aie;
        en_vec[FLG_UF] = ctl.uie;
        irq_cond       = |(flags & en_vec);
    end

    // Output drive.
    always_comb begin
        irq_n  = !irq_cond;
        flag_q = {irq_cond, flags};
        ctl_q  = ctl;
        sqw_o  = ctl.sqwe && sqw_src;
    end

    AST_PF_IRQ: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        (per_tick && ctl.pie && !ctl_wr) |=> !irq_n);  // R1
    AST_ALARM_WILD: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        (upd_done && alm_hr[BYTE_W-1 -: 2] == WILD && alm_min[BYTE_W-1 -: 2] == WILD
         && alm_sec[BYTE_W-1 -: 2] == WILD) |=> flag_q[FLG_AF]);  // R2
    AST_UF_SET: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        upd_done |=> flag_q[FLG_UF]);  // R3
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !pwr_on_n)
        (flags == '0) |-> irq_n);  // R4
    AST_SQW_LOW: assert property (@(posedge clk) disable iff (!pwr_on_n)
        !ctl.sqwe |-> !sqw_o);  // R10

endmodule

// File: tb/sim_rtc_irq_ctrl.sv
module sim_rtc_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, pwr_on_n = 1'b0;
    logic       per_tick = 1'b0, upd_done = 1'b0, ctl_wr = 1'b0, flag_rd = 1'b0, sqw_src = 1'b0;
    logic [7:0] tim_hr = 0, tim_min = 0, tim_sec = 0, alm_hr = 0, alm_min = 0, alm_sec = 0;
    logic [4:0] ctl_wdata = 0;
    logic [4:0] ctl_q;
    logic [3:0] flag_q;
    logic       sqw_o, irq_n;

    int checks = 0, fails = 0;
    logic [4:0] m_ctl;
    logic [2:0] m_flg;   // {pf, af, uf}
    bit         m_valid = 0;

    always #4 clk = ~clk;

    rtc_irq_ctrl u0 (.*);

    function automatic bit fld_hit(input logic [7:0] a, input logic [7:0] t);
        return (a[7:6] == 2'b11) || (a == t);
    endfunction

    function automatic bit exp_irq(input logic [4:0] c, input logic [2:0] f);
        return |(f & {c[3], c[2], c[1]});
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Compare against the model, then advance one clock and update the model.
    task automatic step();
        logic [4:0] nc;
        logic [2:0] nf;
        bit         hit;
        #1;
        if (m_valid) begin
            chk(irq_n == !exp_irq(m_ctl, m_flg), "R4 irq_n", irq_n, !exp_irq(m_ctl, m_flg));
            chk(flag_q == {exp_irq(m_ctl, m_flg), m_flg}, "R5 flag_q", flag_q, {exp_irq(m_ctl, m_flg), m_flg});
            chk(ctl_q == m_ctl, "R11 ctl_q", ctl_q, m_ctl);
            chk(sqw_o == (m_ctl[0] & sqw_src), "R10 sqw_o", sqw_o, m_ctl[0] & sqw_src);
        end
        hit = fld_hit(alm_hr, tim_hr) && fld_hit(alm_min, tim_min) && fld_hit(alm_sec, tim_sec);
        nc = m_ctl; nf = m_flg;
        if (!pwr_on_n) begin
            nc = 5'b00001; nf = 3'b000;
        end else if (!rst_n) begin
            nc[3] = 0; nc[1] = 0; nc[0] = 0; nf = 3'b000;
        end else begin
            if (ctl_wr) begin
                nc = ctl_wdata;
                if (!m_ctl[4] && ctl_wdata[4]) nc[1] = 1'b0;
            end
            if (flag_rd) nf = 3'b000;
            nf = nf | {per_tick, upd_done & hit, upd_done};
        end
        @(posedge clk);
        if (!pwr_on_n) m_valid = 1;
        m_ctl = nc; m_flg = nf;
        @(negedge clk);
    endtask

    task automatic idle();
        per_tick = 0; upd_done = 0; ctl_wr = 0; flag_rd = 0;
    endtask

    task automatic wr_ctl(input logic [4:0] d);
        ctl_wr = 1; ctl_wdata = d; step(); ctl_wr = 0;
    endtask

    task automatic rd_clear();
        flag_rd = 1; step(); flag_rd = 0;
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        @(negedge clk);
        step(); step();
        // R8: power-on state
        chk(ctl_q == 5'b00001, "R8 ctl after power-on", ctl_q, 5'b00001);
        chk(flag_q == 4'b0000 && irq_n, "R8 flags after power-on", {irq_n, flag_q}, 5'b10000);
        pwr_on_n = 1; step(); rst_n = 1; step();

        // R1: flag sets with enable off, line stays high; enabling pulls low
        per_tick = 1; step(); per_tick = 0;
        chk(flag_q[2] == 1 && irq_n == 1, "R1 pf set, pie off", {irq_n, flag_q[2]}, 2'b11);
        wr_ctl(5'b01000);
        chk(irq_n == 0, "R1 pie on drives irq", irq_n, 0);

        // R5: read shows summary, then clears
        flag_rd = 1; #1;
        chk(flag_q == 4'b1100, "R5 read value", flag_q, 4'b1100);
        step(); flag_rd = 0;
        chk(flag_q == 4'b0000 && irq_n, "R5 cleared after read", {irq_n, flag_q}, 5'b10000);

        // R6: set and read in same cycle
        per_tick = 1; flag_rd = 1; step(); idle();
        chk(flag_q[2] == 1, "R6 set beats read", flag_q[2], 1);
        rd_clear();

        // R2: wildcard hours plus exact minutes/seconds
        tim_hr = 8'h10; tim_min = 8'h20; tim_sec = 8'h30;
        alm_hr = 8'hC5; alm_min = 8'h20; alm_sec = 8'h30;
        upd_done = 1; step(); upd_done = 0;
        chk(flag_q[1] == 1, "R2 alarm with wildcard", flag_q[1], 1);
        rd_clear();
        alm_sec = 8'h31;
        upd_done = 1; step(); upd_done = 0;
        chk(flag_q[1] == 0, "R2 seconds mismatch", flag_q[1], 0);
        // R3: update flag sets with uie off, line stays high
        chk(flag_q[0] == 1 && irq_n == 1, "R3 uf set, uie off", {irq_n, flag_q[0]}, 2'b11);
        rd_clear();

        // R9: set rising in the same write as uie
        wr_ctl(5'b10010);
        chk(ctl_q == 5'b10000, "R9 uie cleared on set rise", ctl_q, 5'b10000);
        wr_ctl(5'b10010);
        chk(ctl_q == 5'b10010, "R9 uie kept while set high", ctl_q, 5'b10010);

        // R10: square wave gating
        wr_ctl(5'b10111);
        sqw_src = 1; #1;
        chk(sqw_o == 1, "R10 sqw passes", sqw_o, 1);
        sqw_src = 0; #1;
        chk(sqw_o == 0, "R10 sqw follows low", sqw_o, 0);

        // R7: host reset keeps set-mode and aie
        wr_ctl(5'b11111);
        rst_n = 0; step(); rst_n = 1;
        chk(ctl_q == 5'b10100, "R7 reset clears pie/uie/sqwe", ctl_q, 5'b10100);
        sqw_src = 1; #1;
        chk(sqw_o == 0, "R10 sqw held low", sqw_o, 0);
        wr_ctl(5'b00000);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            per_tick = ($urandom % 4) == 0;
            upd_done = ($urandom % 3) == 0;
            flag_rd  = ($urandom % 5) == 0;
            ctl_wr   = ($urandom % 8) == 0;
            ctl_wdata = 5'($urandom);
            sqw_src  = 1'($urandom);
            tim_hr = 8'($urandom % 3); tim_min = 8'($urandom % 3); tim_sec = 8'($urandom % 3);
            alm_hr  = (($urandom % 4) == 0) ? (8'hC0 | 8'($urandom)) : 8'($urandom % 3);
            alm_min = (($urandom % 4) == 0) ? (8'hC0 | 8'($urandom)) : 8'($urandom % 3);
            alm_sec = (($urandom % 4) == 0) ? (8'hC0 | 8'($urandom)) : 8'($urandom % 3);
            rst_n    = ($urandom % 200) != 0;
            pwr_on_n = ($urandom % 500) != 0;
            step();
        end
        idle(); rst_n = 1; pwr_on_n = 1;
        step();
        summary();
        $finish;
    end
endmodule